// File: doc/BRIEF.md
# Square Wave Tone Channel

A square-wave voice for a retro sound unit. Software programs it through four byte-wide write registers. A period timer, stepped on the half-rate sound clock enable, walks an eight-position duty pattern. An envelope unit sets the amplitude, or a constant volume is used instead. A sweep unit can glide the period up or down on half-frame strobes. A length counter silences the voice once its count runs out.

The frame sequencer that produces the quarter-frame and half-frame strobes sits outside this block, and so does the mixer that uses the 4-bit amplitude. A parameter picks the sweep negation style, so two instances can use one's complement and two's complement respectively.

Writes to the length-halt bit or to the length load that land on the same cycle as a half-frame strobe follow fixed rules. A halt change applies after that cycle's length clock. A reload is dropped only when that cycle's clock decremented a nonzero count.

Top module: `sq_tone_chan`

## Requirements
- R1: All state advances only on cycles with cpu_ce_i high, and writes are taken only on those cycles. Register 0 is duty [7:6], halt/loop [5], constant-volume [4] and volume/envelope period [3:0]. In constant-volume mode amp_o, when not silenced, equals the 4-bit volume. The duty field selects one of four patterns, read left to right over steps 0..7: 0=01000000, 1=01100000, 2=01111000, 3=10011111.
- R2: The 11-bit timer ticks on cycles with both cpu_ce_i and apu_ce_i high. A tick at zero reloads the period and advances the duty step by one, modulo 8. Any other tick decrements the timer. With period P, each duty step therefore lasts 2*(P+1) cycles when apu_ce_i alternates.
- R3: A write to register 3 (length index [7:3], period bits 10:8 in [2:0]) returns the duty step to 0 and sets the envelope restart flag. It leaves the timer count untouched.
- R4: On a quarter-frame strobe with restart set, the envelope clears restart, sets the level to 15 and reloads its divider from the period field. Otherwise a zero divider reloads and the level decrements, or wraps from 0 to 15 when loop is set. A nonzero divider decrements.
- R5: Register 1 is enable [7], divider period [6:4], negate [3] and shift [2:0], and a write to it sets the divider reload flag. On a half-frame strobe with the divider at zero, the period becomes the target when enable is set, shift is nonzero and the channel is not muted. The target is the period plus or minus (period >> shift). With NEG_ONES=1 the subtraction takes one extra off (one's complement); with NEG_ONES=0 it does not.
- R6: amp_o is 0 whenever the period is below 8, or when negate is clear and the add target exceeds 0x7FF. This holds whether or not sweep is enabled.
- R7: Register 3 loads the length count from a 32-entry table (index 0→10, 1→254, 3→2, ...). Each half-frame strobe decrements a nonzero count unless halt is set. len_nz_o reports a nonzero count, and amp_o is 0 while the count is zero. Reset clears all state.
- R8: A halt-bit write on a half-frame strobe cycle does not affect that cycle's length clock. The new halt value governs later strobes.
- R9: A length load on a half-frame strobe cycle is dropped if that cycle decremented a nonzero, unhalted count. Otherwise it is applied.
- R10: While chan_en_i is low the length count is forced to 0 and loads are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_ce_i | input | 1 | CPU-cycle clock enable |
| apu_ce_i | input | 1 | Half-rate enable for the period timer |
| qtr_i | input | 1 | Quarter-frame strobe |
| half_i | input | 1 | Half-frame strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select 0..3 |
| wr_data_i | input | 8 | Write data |
| chan_en_i | input | 1 | Channel enable; low clears the length count |
| len_nz_o | output | 1 | Length count is nonzero |
| amp_o | output | 4 | Amplitude output |

## Verification
Every input takes effect at the first rising edge that samples it. amp_o and len_nz_o are outputs of registered state, so a write or strobe shows at the ports one edge after it is presented. The bench drives inputs after a falling edge and updates its reference model at the rising edge. It compares both outputs of two instances, one per negation style, at the next falling edge, every cycle. The directed cases count edges from the stimulus: the 72-cycle high run of duty 2 with period 8, the 11 edges to the next step after a mid-step phase reset, and the one-edge settling of a coincident halt write or length load against a half-frame strobe.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int REG_W  = 8;
  localparam int PER_W  = 11;
  localparam int LEN_W  = 8;
  localparam int VOL_W  = 4;
  localparam int STEP_W = 3;
  localparam int SWP_W  = 3;
  localparam int IDX_W  = 5;

  function automatic logic [LEN_W-1:0] len_lut(input logic [IDX_W-1:0] idx);
    logic [LEN_W-1:0] v;
    case (idx)
      5'd0:  v = 8'd10;   5'd1:  v = 8'd254; 5'd2:  v = 8'd20;  5'd3:  v = 8'd2;
      5'd4:  v = 8'd40;   5'd5:  v = 8'd4;   5'd6:  v = 8'd80;  5'd7:  v = 8'd6;
      5'd8:  v = 8'd160;  5'd9:  v = 8'd8;   5'd10: v = 8'd60;  5'd11: v = 8'd10;
      5'd12: v = 8'd14;   5'd13: v = 8'd12;  5'd14: v = 8'd26;  5'd15: v = 8'd14;
      5'd16: v = 8'd12;   5'd17: v = 8'd16;  5'd18: v = 8'd24;  5'd19: v = 8'd18;
      5'd20: v = 8'd48;   5'd21: v = 8'd20;  5'd22: v = 8'd96;  5'd23: v = 8'd22;
      5'd24: v = 8'd192;  5'd25: v = 8'd24;  5'd26: v = 8'd72;  5'd27: v = 8'd26;
      5'd28: v = 8'd16;   5'd29: v = 8'd28;  5'd30: v = 8'd32;  default: v = 8'd30;
    endcase
    return v;
  endfunction

  function automatic logic duty_bit(input logic [1:0] duty, input logic [STEP_W-1:0] step);
    logic [7:0] pat;
    case (duty)
      2'd0:    pat = 8'b0100_0000;
      2'd1:    pat = 8'b0110_0000;
      2'd2:    pat = 8'b0111_1000;
      default: pat = 8'b1001_1111;
    endcase
    return pat[3'd7 - step];
  endfunction
endpackage

// File: rtl/sq_seq.sv
module sq_seq import sq_pkg::*; #(
  parameter int PW = PER_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ph_rst_i,
  input  logic [PW-1:0]     period_i,
  input  logic [1:0]        duty_i,
  output logic              high_o
);
  logic [PW-1:0]     tmr_q;
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      step_q <= '0;
    end else begin
      if (tick_i) begin
        if (tmr_q == '0) begin
          tmr_q  <= period_i;
          step_q <= step_q + 1'b1;
        end else begin
          tmr_q <= tmr_q - 1'b1;
        end
      end
      if (ph_rst_i) step_q <= '0;  // divider keeps running
    end
  end

  assign high_o = duty_bit(duty_i, step_q);

  AST_PHASE_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_rst_i |=> step_q == '0); // R3
  AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ph_rst_i && (!tick_i || tmr_q != '0)) |=> $stable(step_q)); // R2
endmodule

// File: rtl/sq_env.sv
module sq_env import sq_pkg::*; #(
  parameter int VW = VOL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          qtr_i,
  input  logic          restart_i,
  input  logic          loop_i,
  input  logic          const_i,
  input  logic [VW-1:0] vol_i,
  output logic [VW-1:0] level_o
);
  logic          start_q;
  logic [VW-1:0] div_q;
  logic [VW-1:0] dec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      div_q   <= '0;
      dec_q   <= '0;
    end else if (ce_i) begin
      if (qtr_i) begin
        if (start_q) begin
          start_q <= 1'b0;
          dec_q   <= '1;
          div_q   <= vol_i;
        end else if (div_q == '0) begin
          div_q <= vol_i;
          if (dec_q != '0)  dec_q <= dec_q - 1'b1;
          else if (loop_i)  dec_q <= '1;
        end else begin
          div_q <= div_q - 1'b1;
        end
      end
      if (restart_i) start_q <= 1'b1;
    end
  end

  assign level_o = const_i ? vol_i : dec_q;

  AST_ENV_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && qtr_i && start_q) |=> dec_q == {VW{1'b1}}); // R4
  AST_ENV_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_i && qtr_i) |=> $stable(dec_q)); // R4
endmodule

// File: rtl/sq_sweep.sv
module sq_sweep import sq_pkg::*; #(
  parameter int PW       = PER_W,
  parameter int SW       = SWP_W,
  parameter bit NEG_ONES = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             half_i,
  input  logic             cfg_wr_i,
  input  logic             lo_wr_i,
  input  logic             hi_wr_i,
  input  logic [REG_W-1:0] data_i,
  output logic [PW-1:0]    period_o,
  output logic             mute_o
);
  localparam logic [PW-1:0] MIN_PER = PW'(8);

  logic          en_q, neg_q, rel_q;
  logic [SW-1:0] per_q, sh_q, div_q;
  logic [PW-1:0] period_q;
  logic [PW:0]   base, chg, tgt_neg, tgt;
  logic          upd;

  assign base = {1'b0, period_q};
  assign chg  = base >> sh_q;

  generate
    if (NEG_ONES) begin : g_ones
      always_comb tgt_neg = base + ~chg;
    end else begin : g_twos
      always_comb tgt_neg = base - chg;
    end
  endgenerate

  assign tgt    = neg_q ? tgt_neg : base + chg;
  assign mute_o = (period_q < MIN_PER) || (!neg_q && tgt[PW]);
  assign upd    = half_i && (div_q == '0) && en_q && (sh_q != '0) && !mute_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      neg_q    <= 1'b0;
      rel_q    <= 1'b0;
      per_q    <= '0;
      sh_q     <= '0;
      div_q    <= '0;
      period_q <= '0;
    end else if (ce_i) begin
      if (half_i) begin
        if (div_q == '0 || rel_q) begin
          div_q <= per_q;
          rel_q <= 1'b0;
        end else begin
          div_q <= div_q - 1'b1;
        end
      end
      if (lo_wr_i)      period_q <= {period_q[PW-1:8], data_i};
      else if (hi_wr_i) period_q <= {data_i[PW-9:0], period_q[7:0]};
      else if (upd)     period_q <= tgt[PW-1:0];
      if (cfg_wr_i) begin
        en_q  <= data_i[7];
        per_q <= data_i[6:4];
        neg_q <= data_i[3];
        sh_q  <= data_i[2:0];
        rel_q <= 1'b1;
      end
    end
  end

  assign period_o = period_q;

  AST_SWEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_i && (half_i || lo_wr_i || hi_wr_i)) |=> $stable(period_q)); // R5
endmodule

// File: rtl/sq_len.sv
module sq_len import sq_pkg::*; #(
  parameter int LW = LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             half_i,
  input  logic             en_i,
  input  logic             halt_wr_i,
  input  logic             halt_d_i,
  input  logic             load_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             halt_o,
  output logic             nz_o
);
  logic [LW-1:0] cnt_q;
  logic          halt_q;
  logic          dec;

  // registered halt: a coincident write only affects later strobes
  assign dec = half_i && !halt_q && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (ce_i) begin
      if (!en_i)               cnt_q <= '0;
      else if (load_i && !dec) cnt_q <= LW'(len_lut(idx_i));
      else if (dec)            cnt_q <= cnt_q - 1'b1;
      if (halt_wr_i) halt_q <= halt_d_i;
    end
  end

  assign halt_o = halt_q;
  assign nz_o   = (cnt_q != '0);

  AST_LEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !en_i) |=> cnt_q == '0); // R10
  AST_LEN_RACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && en_i && half_i && !halt_q && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R9
  AST_LEN_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && en_i && halt_q && !load_i) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/sq_tone_chan.sv
module sq_tone_chan import sq_pkg::*; #(
  parameter bit NEG_ONES = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_ce_i,
  input  logic             apu_ce_i,
  input  logic             qtr_i,
  input  logic             half_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             chan_en_i,
  output logic             len_nz_o,
  output logic [VOL_W-1:0] amp_o
);
  logic             w0, w1, w2, w3, tick;
  logic [1:0]       duty_q;
  logic             cv_q;
  logic [VOL_W-1:0] vol_q;
  logic             halt;
  logic [PER_W-1:0] period;
  logic             mute, high;
  logic [VOL_W-1:0] level;

  assign w0   = cpu_ce_i && wr_en_i && (wr_addr_i == 2'd0);
  assign w1   = cpu_ce_i && wr_en_i && (wr_addr_i == 2'd1);
  assign w2   = cpu_ce_i && wr_en_i && (wr_addr_i == 2'd2);
  assign w3   = cpu_ce_i && wr_en_i && (wr_addr_i == 2'd3);
  assign tick = cpu_ce_i && apu_ce_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      cv_q   <= 1'b0;
      vol_q  <= '0;
    end else if (w0) begin
      duty_q <= wr_data_i[7:6];
      cv_q   <= wr_data_i[4];
      vol_q  <= wr_data_i[VOL_W-1:0];
    end
  end

  sq_seq #(.PW(PER_W)) u_seq (
    .clk_i, .rst_ni, .tick_i(tick), .ph_rst_i(w3),
    .period_i(period), .duty_i(duty_q), .high_o(high)
  );

  sq_env #(.VW(VOL_W)) u_env (
    .clk_i, .rst_ni, .ce_i(cpu_ce_i), .qtr_i, .restart_i(w3),
    .loop_i(halt), .const_i(cv_q), .vol_i(vol_q), .level_o(level)
  );

  sq_sweep #(.PW(PER_W), .SW(SWP_W), .NEG_ONES(NEG_ONES)) u_sweep (
    .clk_i, .rst_ni, .ce_i(cpu_ce_i), .half_i, .cfg_wr_i(w1),
    .lo_wr_i(w2), .hi_wr_i(w3), .data_i(wr_data_i),
    .period_o(period), .mute_o(mute)
  );

  sq_len #(.LW(LEN_W)) u_len (
    .clk_i, .rst_ni, .ce_i(cpu_ce_i), .half_i, .en_i(chan_en_i),
    .halt_wr_i(w0), .halt_d_i(wr_data_i[5]), .load_i(w3),
    .idx_i(wr_data_i[REG_W-1:REG_W-IDX_W]), .halt_o(halt), .nz_o(len_nz_o)
  );

  assign amp_o = (len_nz_o && !mute && high) ? level : '0;

  AST_MUTE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute |-> amp_o == '0); // R6
  AST_LEN_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !len_nz_o |-> amp_o == '0); // R7
  AST_CONST_VOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cv_q && amp_o != '0) |-> amp_o == vol_q); // R1
endmodule

// File: tb/tb_sq_tone_chan.sv
`timescale 1ns/1ps
module tb_sq_tone_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_ce = 1'b1, apu_ce = 1'b0, qtr = 1'b0, half = 1'b0;
  logic wr_en = 1'b0, chan_en = 1'b1;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic nz_a, nz_b;
  logic [3:0] amp_a, amp_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sq_tone_chan #(.NEG_ONES(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_ce_i(cpu_ce), .apu_ce_i(apu_ce), .qtr_i(qtr),
    .half_i(half), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .chan_en_i(chan_en), .len_nz_o(nz_a), .amp_o(amp_a));
  sq_tone_chan #(.NEG_ONES(1'b0)) dut_b (
    .clk_i(clk), .rst_ni(rst_n), .cpu_ce_i(cpu_ce), .apu_ce_i(apu_ce), .qtr_i(qtr),
    .half_i(half), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .chan_en_i(chan_en), .len_nz_o(nz_b), .amp_o(amp_b));

  // reference model: index 0 = one's-complement instance, 1 = two's
  int tab[32] = '{10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14,
                  12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30};
  int pat[4] = '{'h40, 'h60, 'h78, 'h9F};
  int m_per[2], m_tmr[2], m_step[2], m_duty[2], m_halt[2], m_cv[2], m_vol[2];
  int m_len[2], m_start[2], m_dec[2], m_ediv[2];
  int m_sen[2], m_sper[2], m_neg[2], m_sh[2], m_sdiv[2], m_srel[2];

  task automatic m_reset();
    for (int k = 0; k < 2; k++) begin
      m_per[k]=0; m_tmr[k]=0; m_step[k]=0; m_duty[k]=0; m_halt[k]=0; m_cv[k]=0;
      m_vol[k]=0; m_len[k]=0; m_start[k]=0; m_dec[k]=0; m_ediv[k]=0;
      m_sen[k]=0; m_sper[k]=0; m_neg[k]=0; m_sh[k]=0; m_sdiv[k]=0; m_srel[k]=0;
    end
  endtask

  function automatic int m_tgt(int k);
    int ch = m_per[k] >> m_sh[k];
    if (m_neg[k] != 0) return (k == 0) ? m_per[k] - ch - 1 : m_per[k] - ch;
    return m_per[k] + ch;
  endfunction

  function automatic bit m_mute(int k);
    return (m_per[k] < 8) || (m_neg[k] == 0 && m_tgt(k) > 2047);
  endfunction

  function automatic int m_amp(int k);
    int hi = (pat[m_duty[k]] >> (7 - m_step[k])) & 1;
    if (m_len[k] == 0 || m_mute(k) || hi == 0) return 0;
    return (m_cv[k] != 0) ? m_vol[k] : m_dec[k];
  endfunction

  task automatic m_update();
    int d = wr_data;
    bit w0 = wr_en && wr_addr == 0, w1 = wr_en && wr_addr == 1;
    bit w2 = wr_en && wr_addr == 2, w3 = wr_en && wr_addr == 3;
    if (!cpu_ce) return;
    for (int k = 0; k < 2; k++) begin
      bit mt = m_mute(k);
      int tg = m_tgt(k);
      bit upd, lclk;
      if (apu_ce) begin
        if (m_tmr[k] == 0) begin m_tmr[k] = m_per[k]; m_step[k] = (m_step[k] + 1) % 8; end
        else m_tmr[k]--;
      end
      if (w3) m_step[k] = 0;
      if (qtr) begin
        if (m_start[k] != 0) begin m_start[k] = 0; m_dec[k] = 15; m_ediv[k] = m_vol[k]; end
        else if (m_ediv[k] == 0) begin
          m_ediv[k] = m_vol[k];
          if (m_dec[k] > 0) m_dec[k]--; else if (m_halt[k] != 0) m_dec[k] = 15;
        end else m_ediv[k]--;
      end
      if (w3) m_start[k] = 1;
      upd = half && m_sdiv[k] == 0 && m_sen[k] != 0 && m_sh[k] != 0 && !mt;
      if (half) begin
        if (m_sdiv[k] == 0 || m_srel[k] != 0) begin m_sdiv[k] = m_sper[k]; m_srel[k] = 0; end
        else m_sdiv[k]--;
      end
      if (w2) m_per[k] = (m_per[k] & 'h700) | d;
      else if (w3) m_per[k] = (m_per[k] & 'hFF) | ((d & 7) << 8);
      else if (upd) m_per[k] = tg;
      if (w1) begin
        m_sen[k] = d >> 7; m_sper[k] = (d >> 4) & 7; m_neg[k] = (d >> 3) & 1;
        m_sh[k] = d & 7; m_srel[k] = 1;
      end
      lclk = half && m_halt[k] == 0 && m_len[k] != 0;
      if (!chan_en) m_len[k] = 0;
      else if (w3 && !lclk) m_len[k] = tab[d >> 3];
      else if (lclk) m_len[k]--;
      if (w0) begin
        m_duty[k] = d >> 6; m_halt[k] = (d >> 5) & 1; m_cv[k] = (d >> 4) & 1; m_vol[k] = d & 15;
      end
    end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) m_update();
    @(negedge clk);
    if (rst_n) begin
      chk("R2 amp inst0", amp_a, m_amp(0));
      chk("R2 amp inst1", amp_b, m_amp(1));
      chk("R7 len_nz inst0", nz_a, m_len[0] != 0);
      chk("R7 len_nz inst1", nz_b, m_len[1] != 0);
    end
    wr_en = 0; qtr = 0; half = 0; apu_ce = !apu_ce;
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 2'(a); wr_data = 8'(d); step();
  endtask
  task automatic qtrp(int n);
    for (int i = 0; i < n; i++) begin qtr = 1; step(); end
  endtask
  task automatic halfp(int n);
    for (int i = 0; i < n; i++) begin half = 1; step(); end
  endtask
  task automatic maxamp(int n, output int ma, output int mb);
    ma = 0; mb = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (amp_a > ma) ma = amp_a;
      if (amp_b > mb) mb = amp_b;
    end
  endtask
  task automatic wait_amp(bit hi);
    for (int i = 0; i < 400 && ((amp_a != 0) != hi); i++) step();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ma, mb, n;
    int r = 32'h1234_5678;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R7 reset len_nz", nz_a, 0);
    chk("R7 reset amp", amp_a, 0);

    // R1: constant volume, duty 3
    wr(1, 'h08); wr(2, 8); wr(0, 'hD9); wr(3, 'h08);
    maxamp(40, ma, mb);
    chk("R1 const volume", ma, 9);
    chk("R7 load nonzero", nz_a, 1);

    // R2: duty 2 high run = 4 steps * 9 ticks * 2 cycles
    wr(0, 'h99);
    wait_amp(0); wait_amp(1);
    n = 0; while (amp_a != 0 && n < 500) begin n++; step(); end
    chk("R2 duty2 high run", n, 72);
    wr(0, 'h19);
    wait_amp(0); wait_amp(1);
    n = 0; while (amp_a != 0 && n < 500) begin n++; step(); end
    chk("R1 duty0 high run", n, 18);

    // R3: phase reset mid-step, timer not reset
    wait_amp(1);
    repeat (6) step();
    wr(3, 'h08);
    chk("R3 step back to 0", amp_a, 0);
    n = 0; while (amp_a == 0 && n < 100) begin n++; step(); end
    chk("R3 timer kept", n, 11);

    // R4: envelope decay and loop
    wr(0, 'hC0); wr(3, 'h08); qtrp(1);
    maxamp(40, ma, mb); chk("R4 restart level", ma, 15);
    qtrp(3); maxamp(40, ma, mb); chk("R4 decay", ma, 12);
    wr(0, 'hE0); qtrp(12); maxamp(40, ma, mb); chk("R4 reach zero", ma, 0);
    qtrp(1); maxamp(40, ma, mb); chk("R4 loop wrap", ma, 15);

    // R6: mute conditions
    wr(0, 'hDF); wr(2, 7); wr(3, 'h08);
    maxamp(40, ma, mb); chk("R6 low period mute", ma, 0);
    wr(1, 'h00); wr(2, 0); wr(3, 'h0C);
    chk("R6 overflow target mute", amp_a, 0);
    wr(1, 'h01);
    chk("R6 target in range", amp_a, 15);

    // R5: negation styles, period 9 shift 3
    wr(1, 'h8B); wr(2, 9); wr(3, 'h08);
    halfp(1);
    maxamp(40, ma, mb);
    chk("R5 ones complement to 7", ma, 0);
    chk("R5 twos complement to 8", mb, 15);

    // R7: length decrement and halt
    wr(1, 'h08); wr(0, 'hDF); wr(3, 'h18);
    chk("R7 idx3 loaded", nz_a, 1);
    halfp(1); chk("R7 count 1", nz_a, 1);
    halfp(1); chk("R7 count 0", nz_a, 0);
    wr(3, 'h00); halfp(9); chk("R7 idx0 after 9", nz_a, 1);
    halfp(1); chk("R7 idx0 after 10", nz_a, 0);
    wr(0, 'hFF); wr(3, 'h18); halfp(3); chk("R7 halted", nz_a, 1);

    // R8: halt set on strobe cycle still clocks
    wr(0, 'hDF); wr(3, 'h18);
    wr_en = 1; wr_addr = 0; wr_data = 'hFF; half = 1; step();
    halfp(1); chk("R8 halted after race", nz_a, 1);
    wr(0, 'hDF); halfp(1); chk("R8 race clock taken", nz_a, 0);
    // halt clear on strobe cycle does not clock
    wr(0, 'hFF); wr(3, 'h18);
    wr_en = 1; wr_addr = 0; wr_data = 'hDF; half = 1; step();
    halfp(1); chk("R8 old halt blocked clock", nz_a, 1);

    // R9: reload against clock
    wr(0, 'hDF); wr(3, 'h18);
    wr_en = 1; wr_addr = 3; wr_data = 'h18; half = 1; step();
    halfp(1); chk("R9 reload dropped", nz_a, 0);
    wr_en = 1; wr_addr = 3; wr_data = 'h18; half = 1; step();
    chk("R9 reload honoured", nz_a, 1);
    halfp(1); chk("R9 honoured count 1", nz_a, 1);
    halfp(1); chk("R9 honoured count 0", nz_a, 0);

    // R10: disable
    wr(3, 'h08);
    chan_en = 0; step(); chk("R10 forced zero", nz_a, 0);
    wr(3, 'h08); chk("R10 load ignored", nz_a, 0);
    chan_en = 1; step(); chk("R10 stays zero", nz_a, 0);
    wr(3, 'h08); chk("R10 load after enable", nz_a, 1);

    // pseudo-random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      r = r ^ (r << 13); r = r ^ (r >>> 17); r = r ^ (r << 5);
      if ((r & 15) == 0) begin wr_en = 1; wr_addr = 2'(r >> 4); wr_data = 8'(r >> 8); end
      if (((r >> 16) & 31) == 1) half = 1;
      if (((r >> 21) & 7) == 2) qtr = 1;
      if (((r >> 24) & 255) == 3) chan_en = !chan_en;
      step();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule